// File: doc/BRIEF.md
# Polled-Write Byte Memory on a Two-Wire Bus

This block is a two-wire serial bus target that fronts a small byte array of 272 locations (000h to 10Fh). A host on the bus writes one byte at a time using three bytes: a slave address byte, a word address byte and a data byte. It reads one byte back with a random-read sequence: a write of the word address, a repeated START, then the address byte with the read bit set. The slave address byte must carry the device-type code 1010b in its upper nibble. The next three bits must equal the three strap inputs. Writes only take effect while the write-enable input is high.

Each location is tagged by a mask input as volatile or nonvolatile. A write to a volatile location takes effect at STOP and the target is ready at once. A write to a nonvolatile location also starts a timed internal write cycle of `WR_CYCLES` system clocks. During that cycle the target leaves SDA released and refuses every address byte. The host polls for completion by repeating START plus address byte until it gets an ACK.

The word-address map is irregular. Word addresses 00h to FEh reach the location with the same number. Word address FFh reaches location 100h. Location FFh and locations 101h to 10Fh are therefore never reached by these sequences.

The bus is a serial wire pair and carries no parallel data stream, so the block has no valid/ready interface. SCL and SDA are sampled by the system clock. The strap, mask and write-enable inputs are plain level pins.

Top module: `i2c_poll_mem`

## Requirements
- R1: An address byte whose bits 7..4 are not 1010b is not ACKed, and the rest of the transaction is ignored (SDA stays released).
- R2: An address byte is ACKed only if its bits 3..1 equal strap[2], strap[1] and strap[0] in that order. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R3: In a byte write, the target ACKs the address byte, the word address byte and the data byte. It drives SDA low only while SCL is low.
- R4: The array changes only if wel_i was 1 when the eighth data bit was received. Otherwise the addressed location keeps its old value.
- R5: Word addresses 00h to FEh select the locations of the same number, and word address FFh selects location 100h, for both reads and writes.
- R6: After a write to a location whose nv_mask bit is 0, the next address byte right after STOP is ACKed.
- R7: After a write to a location whose nv_mask bit is 1, STOP starts a busy window of WR_CYCLES clocks. In this window every address byte, with either value of bit 0, gets no ACK.
- R8: When the busy window ends, a matching address byte is ACKed again, and the written byte can be read back.
- R9: A random read returns the addressed byte most significant bit first, in the eight clocks after the ACK of the read address byte.
- R10: The array is written only at a STOP that follows a fully ACKed data byte. A STOP in the middle of the data byte, or a START before the STOP, leaves the array unchanged and starts no busy window.
- R11: After reset SDA is released, the target is not busy, and every location reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low; 0 leaves it released |
| strap | input | 3 | Device address straps, compared with address bits 3..1 |
| nv_mask | input | DEPTH | Per-location tag: 1 means nonvolatile |
| wel_i | input | 1 | Write-enable latch level |

## Verification
On every cycle the assertions check the following. SDA is only ever pulled low while the synchronised SCL is low. A refused or skipped transaction never drives SDA. An address byte that ends while the target is busy is never ACKed. The busy counter steps down by one each clock, and a commit never lands inside a busy window. The bench scenarios are needed for the rest: the address map seen through readback, write-enable gating, the effect of aborts on array contents, and the NACK-then-ACK polling sequence of a nonvolatile write.

// File: rtl/i2c_poll_mem_pkg.sv
package i2c_poll_mem_pkg;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int unsigned DEPTH     = 272,
  parameter int unsigned WR_CYCLES = 250000,
  parameter int unsigned LOC_W     = 9,
  parameter int unsigned CNT_W     = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [LOC_W-1:0] loc,
  input  logic [7:0]       wr_data,
  input  logic [DEPTH-1:0] nv_mask,
  output logic [7:0]       rd_data,
  output logic             busy
);
  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt;
  logic             in_range;

  assign in_range = (loc < LOC_W'(DEPTH));
  assign rd_data  = in_range ? mem[loc] : 8'h00;
  assign busy     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= 8'h00;
      cnt <= '0;
    end else begin
      if (commit && in_range) mem[loc] <= wr_data;
      if (commit && in_range && nv_mask[loc]) cnt <= CNT_W'(WR_CYCLES);
      else if (busy) cnt <= cnt - 1'b1;
    end
  end

  p_busy_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> (cnt == $past(cnt) - 1'b1));

  p_commit_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_poll_mem_pkg::*;
#(
  parameter int unsigned LOC_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_q,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [2:0]       strap,
  input  logic             wel_i,
  input  logic             busy,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             commit,
  output logic [LOC_W-1:0] loc,
  output logic [7:0]       wr_data
);
  phase_t     phase, nxt;
  logic [3:0] bitcnt;
  logic [7:0] sh, waddr;
  logic       in_ack, pend_arm, pend_valid;
  logic       match;

  assign loc   = (waddr == 8'hFF) ? LOC_W'(256) : LOC_W'(waddr);
  assign match = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;  nxt <= PH_IDLE;
      bitcnt <= '0;      sh <= '0;
      waddr <= '0;       wr_data <= '0;
      in_ack <= 1'b0;    pend_arm <= 1'b0;
      pend_valid <= 1'b0; sda_oe <= 1'b0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_evt) begin
        phase <= PH_ADDR;  bitcnt <= '0;
        in_ack <= 1'b0;    sda_oe <= 1'b0;
        pend_valid <= 1'b0;
      end else if (stop_evt) begin
        commit <= pend_valid;  pend_valid <= 1'b0;
        phase <= PH_IDLE;      in_ack <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (!in_ack && phase != PH_IDLE && phase != PH_SKIP) begin
          sh     <= {sh[6:0], sda_q};
          bitcnt <= bitcnt + 1'b1;
        end
      end else if (scl_fall) begin
        if (in_ack) begin
          in_ack <= 1'b0;
          bitcnt <= '0;
          phase  <= nxt;
          sda_oe <= (nxt == PH_RDATA) ? ~rd_data[7] : 1'b0;
          if (phase == PH_WDATA) pend_valid <= pend_arm;
        end else if (bitcnt == 4'd8) begin
          case (phase)
            PH_ADDR: begin
              if (match) begin
                sda_oe <= 1'b1;  in_ack <= 1'b1;
                nxt    <= sh[0] ? PH_RDATA : PH_WADDR;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_WADDR: begin
              waddr <= sh;  sda_oe <= 1'b1;
              in_ack <= 1'b1;  nxt <= PH_WDATA;
            end
            PH_WDATA: begin
              wr_data <= sh;  pend_arm <= wel_i;
              sda_oe <= 1'b1;  in_ack <= 1'b1;
              nxt <= PH_SKIP;
            end
            PH_RDATA: begin
              sda_oe <= 1'b0;  in_ack <= 1'b1;
              nxt <= PH_SKIP;
            end
            default: ;
          endcase
        end else if (phase == PH_RDATA) begin
          sda_oe <= ~rd_data[3'(4'd7 - bitcnt)];
        end
      end
    end
  end

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ADDR && scl_fall && !in_ack && bitcnt == 4'd8 && busy) |=> !sda_oe);

  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP && !in_ack) |-> !sda_oe);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_poll_mem.sv
module i2c_poll_mem #(
  parameter int unsigned DEPTH     = 272,
  parameter int unsigned WR_CYCLES = 250000,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [2:0]       strap,
  input  logic [DEPTH-1:0] nv_mask,
  input  logic             wel_i
);
  localparam int unsigned LOC_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic commit, busy;
  logic [LOC_W-1:0] loc;
  logic [7:0] wr_data, rd_data;

  i2c_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_mem_fsm #(.LOC_W(LOC_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap), .wel_i(wel_i), .busy(busy), .rd_data(rd_data),
    .sda_oe(sda_oe), .commit(commit), .loc(loc), .wr_data(wr_data)
  );

  i2c_mem_store #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYCLES), .LOC_W(LOC_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .loc(loc), .wr_data(wr_data),
    .nv_mask(nv_mask), .rd_data(rd_data), .busy(busy)
  );
endmodule

// File: tb/tb_i2c_poll_mem.sv
module tb_i2c_poll_mem;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 272;
  localparam int WR_CYC     = 2000;
  localparam int Q          = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int NV = 7;
  // {wel, word address, data}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'hA5}, {1'b1, 8'h7F, 8'h3C}, {1'b1, 8'hFE, 8'h81},
    {1'b1, 8'hFF, 8'h5A}, {1'b0, 8'h10, 8'h77}, {1'b0, 8'hFE, 8'h11},
    {1'b1, 8'h10, 8'hE7}
  };

  logic clk = 0, rst_n = 0, scl = 1, m_low = 0, wel = 1;
  logic sda_oe, sda_line;
  logic [DEPTH-1:0] nv_mask;
  logic [7:0] model [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  assign sda_line = ~(sda_oe | m_low);
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_poll_mem #(.DEPTH(DEPTH), .WR_CYCLES(WR_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(STRAP), .nv_mask(nv_mask), .wel_i(wel)
  );

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 0; tick(Q); scl = 1; tick(Q); m_low = 1; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic bus_stop();
    m_low = 1; tick(Q); scl = 1; tick(Q); m_low = 0; tick(Q);
  endtask
  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_low = ~b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
  endtask
  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    m_low = 0; tick(Q); scl = 1; tick(Q); ack = ~sda_line; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      m_low = 0; tick(Q); scl = 1; tick(Q); b[i] = sda_line; tick(Q); scl = 0; tick(Q);
    end
    m_low = mack; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); m_low = 0;
  endtask

  task automatic wr_txn(logic [7:0] w, logic [7:0] d, output int acks);
    bit a;
    acks = 0;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a); acks += int'(a);
    send_byte(w, a); acks += int'(a);
    send_byte(d, a); acks += int'(a);
    bus_stop();
  endtask
  task automatic rd_txn(logic [7:0] w, output logic [7:0] d);
    bit a;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    send_byte(w, a);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask
  task automatic poll(logic [7:0] ab, output bit ack);
    logic [7:0] junk;
    bus_start();
    send_byte(ab, ack);
    if (ack && ab[0]) recv_byte(junk, 1'b0);
    bus_stop();
  endtask
  function automatic int map(logic [7:0] w);
    return (w == 8'hFF) ? 256 : int'(w);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int acks, nacks;
    bit a;
    nv_mask = '0;
    for (int i = 8'h40; i < 8'h50; i++) nv_mask[i] = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    tick(5); rst_n = 1; tick(5);

    // R11: reset state
    check(sda_oe == 1'b0, "R11 sda released", int'(sda_oe), 0);
    rd_txn(8'h00, d);
    check(d == 8'h00, "R11 reset contents", int'(d), 0);

    // vector walk: R3 acks, R4 gating, R5 map, R9 readback
    for (int i = 0; i < NV; i++) begin
      wel = VEC[i][16];
      wr_txn(VEC[i][15:8], VEC[i][7:0], acks);
      check(acks == 3, "R3 three acks", acks, 3);
      if (VEC[i][16]) model[map(VEC[i][15:8])] = VEC[i][7:0];
      rd_txn(VEC[i][15:8], d);
      check(d == model[map(VEC[i][15:8])], "R4/R5/R9 readback", int'(d),
            int'(model[map(VEC[i][15:8])]));
    end
    wel = 1;
    rd_txn(8'hFE, d);
    check(d == model[8'hFE], "R5 FFh does not alias FEh", int'(d), int'(model[8'hFE]));

    // R1: wrong device type
    poll({4'b1011, STRAP, 1'b0}, a);
    check(!a, "R1 wrong type nack", int'(a), 0);
    // R2: strap mismatch, then match with read bit
    poll({4'b1010, 3'b100, 1'b0}, a);
    check(!a, "R2 strap mismatch nack", int'(a), 0);
    poll({4'b1010, STRAP, 1'b1}, a);
    check(a, "R2 read address ack", int'(a), 1);

    // R6: volatile write then immediate ack
    wr_txn(8'h22, 8'h4D, acks); model[8'h22] = 8'h4D;
    poll({4'b1010, STRAP, 1'b0}, a);
    check(a, "R6 ready after volatile write", int'(a), 1);

    // R7/R8: nonvolatile write and polling
    wr_txn(8'h40, 8'hC3, acks); model[8'h40] = 8'hC3;
    poll({4'b1010, STRAP, 1'b0}, a);
    check(!a, "R7 busy nack write poll", int'(a), 0);
    poll({4'b1010, STRAP, 1'b1}, a);
    check(!a, "R7 busy nack read poll", int'(a), 0);
    nacks = 2;
    a = 0;
    for (int k = 0; k < 20 && !a; k++) begin
      poll({4'b1010, STRAP, 1'b0}, a);
      if (!a) nacks++;
    end
    check(a, "R8 ack after write cycle", int'(a), 1);
    check(nacks <= 8, "R8 busy window length", nacks, 8);
    rd_txn(8'h40, d);
    check(d == 8'hC3, "R8 nonvolatile readback", int'(d), 8'hC3);

    // R10: STOP in the middle of the data byte
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    send_byte(8'h30, a);
    send_bits(8'h99, 4);
    bus_stop();
    rd_txn(8'h30, d);
    check(d == model[8'h30], "R10 mid-byte stop", int'(d), int'(model[8'h30]));
    // R10: START before STOP on a nonvolatile location
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, a);
    send_byte(8'h41, a);
    send_byte(8'h66, a);
    bus_start();
    bus_stop();
    poll({4'b1010, STRAP, 1'b0}, a);
    check(a, "R10 no busy after abort", int'(a), 1);
    rd_txn(8'h41, d);
    check(d == model[8'h41], "R10 abort keeps array", int'(d), int'(model[8'h41]));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule